// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block sits on the host side of a three-wire link to a 12-bit differential sampling converter. It owns the link: it drives the active-low chip select and the serial clock, and it takes in the converter's data line. When a start request arrives while the block is idle, it pulls chip select low. It then runs the serial clock at a rate set by a divider input. It shifts in the result and returns a signed sample together with a single-cycle valid strobe.

The converter needs two falling clock edges to acquire its input. It then sends a null bit, followed by the 12-bit result MSB first. If chip select is still low after the last bit, the converter sends the word again LSB first. In this repeat the LSB is not resent. A mode input chooses between two frame lengths:

- **Short frame:** chip select is released before the repeat starts.
- **Long frame:** the controller keeps chip select low through the reversed copy and compares it with the first word. Any difference raises a mismatch flag next to the sample.

After each frame, chip select stays high for a fixed guard time before the next start is accepted.

Top module: `adc_rd_ctrl`

## Requirements
- R1: During and right after reset, cs_no and sclk_o are high, and valid_o and mismatch_o are low. busy_o stays high while the block counts out the guard time, then drops within GUARD+2 cycles.
- R2: A start_i pulse while busy_o is low makes cs_no low and busy_o high in the next cycle. The block also latches long_mode_i and div_i at that moment.
- R3: Each half period of sclk_o lasts div_i+1 system clocks. sclk_o is high when the frame begins.
- R4: A short frame (long_mode_i = 0) has exactly 14 falling edges of sclk_o. It keeps cs_no low for (2*14+1)*(div_i+1) cycles.
- R5: A long frame (long_mode_i = 1) has exactly 25 falling edges. It keeps cs_no low for (2*25+1)*(div_i+1) cycles.
- R6: The controller samples sdata_i on each rising sclk_o edge, and numbers rising edges from 1. Rising edges 3 to 14 carry B11 down to B0, and sample_o takes these bits as a two's-complement value.
- R7: In a long frame, rising edges 15 to 25 carry B1 up to B11. mismatch_o goes high with the sample if any of these bits differs from the same bit of the first word.
- R8: In a short frame, mismatch_o is low whenever valid_o is high.
- R9: valid_o is high for exactly one cycle per frame, in the cycle that cs_no returns high. sample_o and mismatch_o change only in that cycle.
- R10: After a frame, cs_no stays high for at least GUARD cycles before it falls again.
- R11: A start_i pulse while busy_o is high starts no frame. This holds both during a frame and during the guard time.
- R12: sclk_o is high whenever cs_no is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one conversion frame |
| long_mode_i | input | 1 | 1 = capture and check the reversed repeat |
| div_i | input | DIV_W | Serial clock half period, in system clocks, minus one |
| cs_no | output | 1 | Active-low chip select to the converter |
| sclk_o | output | 1 | Serial clock to the converter |
| sdata_i | input | 1 | Serial data from the converter |
| sample_o | output | W | Signed result of the last frame |
| valid_o | output | 1 | One-cycle strobe marking a new sample |
| mismatch_o | output | 1 | Repeat disagreed with the first word |
| busy_o | output | 1 | Frame or guard time in progress |

## Verification
The bench runs the extreme two's-complement codes 0x7FF, 0x800 and 0xFFF. A design that dropped the null bit or shifted the capture window by one edge would return these values wrong by a factor of two or with the wrong sign. In long frames the converter model corrupts the first repeated bit (B1) and, separately, the last one (B11). An off-by-one in the repeat window or the comparison would miss one of these faults, or flag a clean frame. The bench also counts falling edges and chip-select low time at divider values 0, 1, 2 and 3, which exposes a wrong frame length or half period. Start pulses sent in the middle of a frame and during the guard time would show up as extra chip-select falls if the block accepted them.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FRAME = 2'd1,
    ST_HOLD  = 2'd2,
    ST_GUARD = 2'd3
  } seq_st_t;
endpackage

// File: rtl/adc_rd_clkdiv.sv
module adc_rd_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (!run_i) begin
      ph_d = '0;
    end else if (ph_q == div_i) begin
      ph_d = '0;
    end else begin
      ph_d = ph_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= '0;
    end else begin
      ph_q <= ph_d;
    end
  end

  assign tick_o = run_i && (ph_q == div_i);
endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq
  import adc_rd_pkg::*;
#(
  parameter int W     = 12,
  parameter int DIV_W = 8,
  parameter int GUARD = 4,
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             long_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             tick_i,
  output logic             run_o,
  output logic [DIV_W-1:0] div_q_o,
  output logic             long_q_o,
  output logic             cs_no,
  output logic             sclk_o,
  output logic             busy_o,
  output logic             bit_stb_o,
  output logic [CNT_W-1:0] bit_idx_o,
  output logic             done_o
);
  localparam int LEN_S  = W + 2;
  localparam int LEN_L  = 2 * W + 1;
  localparam int GCNT_W = $clog2(GUARD + 1);

  seq_st_t          st_q, st_d;
  logic             cs_q, cs_d;
  logic             sclk_q, sclk_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [GCNT_W-1:0] gcnt_q, gcnt_d;
  logic             long_q, long_d;
  logic [DIV_W-1:0] div_q, div_d;
  logic [CNT_W-1:0] len_sel;
  logic [CNT_W-1:0] cnt_inc;

  assign len_sel = long_q ? CNT_W'(LEN_L) : CNT_W'(LEN_S);
  assign cnt_inc = cnt_q + CNT_W'(1);

  always_comb begin
    st_d   = st_q;
    cs_d   = cs_q;
    sclk_d = sclk_q;
    cnt_d  = cnt_q;
    gcnt_d = gcnt_q;
    long_d = long_q;
    div_d  = div_q;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d   = ST_FRAME;
          cs_d   = 1'b0;
          cnt_d  = '0;
          long_d = long_i;
          div_d  = div_i;
        end
      end
      ST_FRAME: begin
        if (tick_i) begin
          sclk_d = !sclk_q;
          if (!sclk_q) begin
            cnt_d = cnt_inc;
            if (cnt_inc == len_sel) begin
              st_d = ST_HOLD;
            end
          end
        end
      end
      ST_HOLD: begin
        if (tick_i) begin
          cs_d   = 1'b1;
          st_d   = ST_GUARD;
          gcnt_d = '0;
        end
      end
      default: begin
        if (gcnt_q == GCNT_W'(GUARD - 1)) begin
          st_d = ST_IDLE;
        end else begin
          gcnt_d = gcnt_q + GCNT_W'(1);
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_GUARD;
      cs_q   <= 1'b1;
      sclk_q <= 1'b1;
      cnt_q  <= '0;
      gcnt_q <= '0;
      long_q <= 1'b0;
      div_q  <= '0;
    end else begin
      st_q   <= st_d;
      cs_q   <= cs_d;
      sclk_q <= sclk_d;
      cnt_q  <= cnt_d;
      gcnt_q <= gcnt_d;
      long_q <= long_d;
      div_q  <= div_d;
    end
  end

  assign run_o     = (st_q == ST_FRAME) || (st_q == ST_HOLD);
  assign div_q_o   = div_q;
  assign long_q_o  = long_q;
  assign cs_no     = cs_q;
  assign sclk_o    = sclk_q;
  assign busy_o    = (st_q != ST_IDLE);
  assign bit_stb_o = (st_q == ST_FRAME) && tick_i && !sclk_q;
  assign bit_idx_o = cnt_inc;
  assign done_o    = (st_q == ST_HOLD) && tick_i;

  // Cycles spent with chip select high, saturating; for the guard check only.
  logic [GCNT_W:0] hi_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt_q <= '0;
    end else if (!cs_q) begin
      hi_cnt_q <= '0;
    end else if (hi_cnt_q < (GCNT_W + 1)'(GUARD)) begin
      hi_cnt_q <= hi_cnt_q + (GCNT_W + 1)'(1);
    end
  end

  // R10
  guard_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_q) |-> (hi_cnt_q >= (GCNT_W + 1)'(GUARD)));

  // R2
  start_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (!cs_no && busy_o));

  // R11
  start_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && cs_no && $past(cs_no)) |=> !$fell(cs_no));

  // R12
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> sclk_o);
endmodule

// File: rtl/adc_rd_capture.sv
module adc_rd_capture #(
  parameter int W     = 12,
  parameter int CNT_W = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bit_stb_i,
  input  logic [CNT_W-1:0]    bit_idx_i,
  input  logic                sdata_i,
  input  logic                done_i,
  input  logic                long_i,
  output logic signed [W-1:0] sample_o,
  output logic                valid_o,
  output logic                mismatch_o
);
  localparam int WORD_F = 3;
  localparam int WORD_L = W + 2;
  localparam int REP_F  = W + 3;
  localparam int REP_L  = 2 * W + 1;

  logic [W-1:0] word_q, word_d;
  logic [W-2:0] rep_q, rep_d;
  logic [W-1:0] smp_q, smp_d;
  logic         vld_q, vld_d;
  logic         mm_q, mm_d;
  logic         in_word, in_rep;

  assign in_word = bit_stb_i && (bit_idx_i >= CNT_W'(WORD_F)) && (bit_idx_i <= CNT_W'(WORD_L));
  assign in_rep  = bit_stb_i && (bit_idx_i >= CNT_W'(REP_F)) && (bit_idx_i <= CNT_W'(REP_L));

  always_comb begin
    word_d = word_q;
    rep_d  = rep_q;
    smp_d  = smp_q;
    mm_d   = mm_q;
    vld_d  = done_i;
    if (in_word) begin
      word_d = {word_q[W-2:0], sdata_i};
    end
    if (in_rep) begin
      rep_d = {sdata_i, rep_q[W-2:1]};
    end
    if (done_i) begin
      smp_d = word_q;
      mm_d  = long_i && (rep_q != word_q[W-1:1]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q <= '0;
      rep_q  <= '0;
      smp_q  <= '0;
      vld_q  <= 1'b0;
      mm_q   <= 1'b0;
    end else begin
      word_q <= word_d;
      rep_q  <= rep_d;
      smp_q  <= smp_d;
      vld_q  <= vld_d;
      mm_q   <= mm_d;
    end
  end

  assign sample_o   = $signed(smp_q);
  assign valid_o    = vld_q;
  assign mismatch_o = mm_q;

  // R8
  short_no_mm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !long_i) |-> !mismatch_o);

  // R9
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R9
  sample_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sample_o) |-> valid_o);
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl #(
  parameter int W     = 12,
  parameter int DIV_W = 8,
  parameter int GUARD = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                long_mode_i,
  input  logic [DIV_W-1:0]    div_i,
  output logic                cs_no,
  output logic                sclk_o,
  input  logic                sdata_i,
  output logic signed [W-1:0] sample_o,
  output logic                valid_o,
  output logic                mismatch_o,
  output logic                busy_o
);
  localparam int CNT_W = $clog2(2 * W + 2);

  logic             run;
  logic             tick;
  logic [DIV_W-1:0] div_q;
  logic             long_q;
  logic             bit_stb;
  logic [CNT_W-1:0] bit_idx;
  logic             done;

  adc_rd_clkdiv #(.DIV_W(DIV_W)) i_clkdiv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .div_i  (div_q),
    .tick_o (tick)
  );

  adc_rd_seq #(.W(W), .DIV_W(DIV_W), .GUARD(GUARD), .CNT_W(CNT_W)) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .long_i    (long_mode_i),
    .div_i     (div_i),
    .tick_i    (tick),
    .run_o     (run),
    .div_q_o   (div_q),
    .long_q_o  (long_q),
    .cs_no     (cs_no),
    .sclk_o    (sclk_o),
    .busy_o    (busy_o),
    .bit_stb_o (bit_stb),
    .bit_idx_o (bit_idx),
    .done_o    (done)
  );

  adc_rd_capture #(.W(W), .CNT_W(CNT_W)) i_capture (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_stb_i  (bit_stb),
    .bit_idx_i  (bit_idx),
    .sdata_i    (sdata_i),
    .done_i     (done),
    .long_i     (long_q),
    .sample_o   (sample_o),
    .valid_o    (valid_o),
    .mismatch_o (mismatch_o)
  );
endmodule

// File: tb/test_adc_rd_ctrl.sv
module test_adc_rd_ctrl;
  localparam int W = 12;
  localparam int DIV_W = 8;
  localparam int GUARD = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic long_mode = 1'b0;
  logic [DIV_W-1:0] div = '0;
  logic cs_n, sclk, sdata, valid, mm, busy;
  logic signed [W-1:0] sample;

  always #5 clk = ~clk;

  adc_rd_ctrl #(.W(W), .DIV_W(DIV_W), .GUARD(GUARD)) i_adc_rd_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .long_mode_i(long_mode),
    .div_i(div), .cs_no(cs_n), .sclk_o(sclk), .sdata_i(sdata),
    .sample_o(sample), .valid_o(valid), .mismatch_o(mm), .busy_o(busy));

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Converter model: drives on falling sclk, high when not driving.
  logic [W-1:0] mval = '0;
  int corr_k = 0;
  int fall_n = 0;
  initial sdata = 1'b1;
  always @(negedge sclk) begin
    if (!cs_n) begin
      fall_n = fall_n + 1;
      if (fall_n == 2) sdata = 1'b0;
      else if (fall_n >= 3 && fall_n <= W + 2) sdata = mval[W + 2 - fall_n];
      else if (fall_n >= W + 3 && fall_n <= 2 * W + 1)
        sdata = mval[fall_n - W - 2] ^ (fall_n == corr_k);
      else sdata = 1'b1;
    end
  end
  always @(posedge cs_n) begin
    fall_n = 0;
    sdata = 1'b1;
  end

  typedef struct {
    int smp;
    bit mm;
    int len;
    int dv;
  } exp_t;
  exp_t sb[$];

  // Monitor
  int low_cyc = 0, sclk_low = 0, falls = 0, cs_falls = 0, idle_viol = 0;
  logic prev_sclk = 1'b1, prev_cs = 1'b1, prev_valid = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!cs_n) low_cyc++;
      if (!cs_n && !sclk) sclk_low++;
      if (prev_sclk && !sclk) falls++;
      if (prev_cs && !cs_n) cs_falls++;
      if (cs_n && !sclk) idle_viol++;
      if (prev_valid) chk(!valid, "R9 valid width", int'(valid), 0);
      if (valid) begin
        if (sb.size() == 0) begin
          chk(0, "R9 unexpected valid", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          chk(int'(sample) == e.smp, "R6 sample", int'(sample), e.smp);
          chk(mm == e.mm, e.len > W + 2 ? "R7 mismatch" : "R8 mismatch", int'(mm), int'(e.mm));
          chk(falls == e.len, e.len > W + 2 ? "R5 falls" : "R4 falls", falls, e.len);
          chk(low_cyc == (2 * e.len + 1) * (e.dv + 1), "R4 R5 cs low", low_cyc,
              (2 * e.len + 1) * (e.dv + 1));
          chk(sclk_low == e.len * (e.dv + 1), "R3 half period", sclk_low, e.len * (e.dv + 1));
          chk(cs_n, "R9 valid with cs high", int'(cs_n), 1);
        end
        low_cyc = 0;
        sclk_low = 0;
        falls = 0;
      end
      prev_sclk = sclk;
      prev_cs = cs_n;
      prev_valid = valid;
    end
  end

  int frames = 0;
  task automatic do_frame(logic [W-1:0] v, bit lg, int ck, int dv, bit poke);
    exp_t e;
    while (busy) @(negedge clk);
    mval = v;
    corr_k = ck;
    long_mode = lg;
    div = DIV_W'(dv);
    start = 1'b1;
    e.smp = int'($signed(v));
    e.mm = lg && (ck != 0);
    e.len = lg ? 2 * W + 1 : W + 2;
    e.dv = dv;
    sb.push_back(e);
    frames++;
    @(negedge clk);
    start = 1'b0;
    long_mode = !lg;
    div = DIV_W'(dv + 5);
    chk(!cs_n && busy, "R2 start accepted", int'(cs_n), 0);
    if (poke) begin
      repeat (5) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      @(posedge cs_n);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // R11: cs stays high through the guard time despite the pulse
      chk(cs_n, "R11 start during guard", int'(cs_n), 1);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(cs_n, "R1 cs reset", int'(cs_n), 1);
    chk(sclk, "R1 sclk reset", int'(sclk), 1);
    chk(!valid && !mm, "R1 valid/mismatch reset", int'(valid), 0);
    rst_n = 1'b1;
    repeat (GUARD + 2) @(negedge clk);
    chk(!busy, "R1 busy drops after guard", int'(busy), 0);

    do_frame(12'h7FF, 1'b0, 0, 0, 1'b0);
    do_frame(12'h800, 1'b0, 0, 1, 1'b0);
    do_frame(12'hA5C, 1'b1, 0, 0, 1'b0);
    do_frame(12'h3C1, 1'b1, W + 3, 1, 1'b0);
    do_frame(12'h001, 1'b1, 2 * W + 1, 0, 1'b0);
    do_frame(12'hFFF, 1'b0, 0, 3, 1'b1);
    do_frame(12'h5A5, 1'b1, 0, 2, 1'b1);
    do_frame(12'h000, 1'b1, 0, 0, 1'b0);
    while (busy || sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(cs_falls == frames, "R11 frame count", cs_falls, frames);
    chk(idle_viol == 0, "R12 sclk idle high", idle_viol, 0);
    chk(sb.size() == 0, "R9 all samples seen", sb.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule